// File: doc/BRIEF.md
# Single-Bus Processor Datapath

This block is the datapath of a small 16-bit load/store machine in which every register-to-register transfer travels over one shared bus. Five sources can drive that bus: the external register file, the external word memory, the ALU, the program counter and a sign-extended immediate taken from the instruction register. Six destinations can capture it on a clock edge: the program counter, instruction register, memory address register, the two ALU operand registers and the one-bit zero flag.

A microcoded or hard-wired controller outside the block supplies one control word per cycle. That word holds the driver enables, the load enables, the memory and register-file write strobes, a two-bit ALU function and a two-bit register-field select. In return the controller reads back the instruction opcode and the zero flag. The register file itself lives outside the block. The datapath tells it which register index to use, taken from the instruction fields, and hands it the bus value as write data.

Top module: `sbus_datapath`

## Requirements
- R1: A synchronous active-high reset clears PC, IR, MAR, A, B and the zero flag, so that afterwards the PC drives 16'h0000, the opcode and memory address read zero, and the flag reads 0.
- R2: The bus carries the value of the single enabled source, with enables for register file, memory, ALU, PC and immediate. With no enable asserted the bus reads 16'h0000.
- R3: The ALU output follows the function code: 2'b00 gives A+B, 2'b01 gives NOT(A AND B), 2'b10 gives A−B and 2'b11 gives A+1. All results wrap modulo 2^16, so 16'hFFFF+1 gives 16'h0000.
- R4: The immediate source drives IR bits 4..0, read as two's complement and sign-extended to 16 bits.
- R5: On a rising edge, each of PC, IR, MAR, A and B captures the bus when its load enable is high and keeps its value otherwise.
- R6: When its load enable is high, the zero flag captures 1 if the ALU output equals 16'h0000 at that edge and 0 if it does not. Otherwise the flag holds.
- R7: The memory address output equals MAR. The memory write strobe follows its control input in the same cycle, and the write data is the bus value.
- R8: The opcode output equals IR bits 15..13.
- R9: The register index output follows the two-bit select: 2'b00 gives IR[12:9], 2'b01 gives IR[8:5], 2'b10 gives IR[4:1] and 2'b11 gives 0. The register-file write strobe follows its control input in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| en_rf | input | 1 | Register file drives the bus |
| en_mem | input | 1 | Memory read data drives the bus |
| en_alu | input | 1 | ALU output drives the bus |
| en_pc | input | 1 | PC drives the bus |
| en_imm | input | 1 | Sign-extended immediate drives the bus |
| ld_pc | input | 1 | Load PC from the bus |
| ld_ir | input | 1 | Load IR from the bus |
| ld_mar | input | 1 | Load MAR from the bus |
| ld_a | input | 1 | Load operand A from the bus |
| ld_b | input | 1 | Load operand B from the bus |
| ld_z | input | 1 | Load the zero flag from the ALU zero test |
| wr_mem | input | 1 | Memory write strobe request |
| wr_rf | input | 1 | Register file write strobe request |
| alu_fn | input | 2 | ALU function code |
| reg_sel | input | 2 | Instruction field used as register index |
| mem_rdata | input | 16 | Memory read data |
| rf_rdata | input | 16 | Register file read data |
| mem_addr | output | 16 | Word address, from MAR |
| mem_we | output | 1 | Memory write enable |
| rf_idx | output | 4 | Register file index |
| rf_we | output | 1 | Register file write enable |
| bus_o | output | 16 | Bus value, used as write data for memory and register file |
| opcode | output | 3 | IR opcode field |
| zflag | output | 1 | Zero flag |

## Verification
Each bus source is enabled on its own with a distinct word, and then no source is enabled, so that a swapped or leaking source and a floating idle bus show up as wrong values. The ALU is given operands whose sum, NAND, difference and increment all differ, plus an all-ones operand for the increment wrap. Instruction words with the immediate sign bit set and clear separate a correct sign extension from zero extension or a wrong bit range, and the same words check the opcode and each register-field select. The zero flag is loaded once with equal operands, once with unequal ones, and is then left unloaded while the ALU output is zero, which tells capture apart from a flag that simply follows the output.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

   typedef enum logic [1:0] {
      FN_ADD  = 2'b00,
      FN_NAND = 2'b01,
      FN_SUB  = 2'b10,
      FN_INC  = 2'b11
   } alu_fn_e;

   typedef enum logic [1:0] {
      SEL_X    = 2'b00,
      SEL_Y    = 2'b01,
      SEL_Z    = 2'b10,
      SEL_NONE = 2'b11
   } reg_sel_e;

   // bus source lanes
   localparam int SRC_RF  = 0;
   localparam int SRC_MEM = 1;
   localparam int SRC_ALU = 2;
   localparam int SRC_PC  = 3;
   localparam int SRC_IMM = 4;
   localparam int N_SRC   = 5;

endpackage

// File: rtl/sbus_ldreg.sv
module sbus_ldreg #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         ld,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (W < 1) begin : g_bad_w
         $error("sbus_ldreg: W must be positive");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)     q <= '0;
      else if (ld) q <= d;
   end

   AST_HOLD_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (rst)
      !ld |=> $stable(q)) else $error("register changed without load"); // R5

endmodule

// File: rtl/sbus_alu.sv
module sbus_alu
   import sbus_pkg::*;
#(
   parameter int W = 16
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [1:0]   fn,
   output logic [W-1:0] y,
   output logic         is_zero
);

   generate
      if (W < 2) begin : g_bad_w
         $error("sbus_alu: W must be at least 2");
      end
   endgenerate

   localparam logic [W-1:0] ONE = W'(1);

   always_comb begin
      unique case (alu_fn_e'(fn))
         FN_ADD:  y = a + b;
         FN_NAND: y = ~(a & b);
         FN_SUB:  y = a - b;
         FN_INC:  y = a + ONE;
         default: y = '0;
      endcase
   end

   assign is_zero = (y == '0);

   always_comb begin
      if (fn == 2'b01 && (a & b) == '0)
         AST_NAND_DISJOINT_ONES: assert (y == '1) else $error("nand of disjoint operands"); // R3
   end

endmodule

// File: rtl/sbus_busmux.sv
module sbus_busmux #(
   parameter int W = 16,
   parameter int N = 5
) (
   input  logic [N-1:0] en,
   input  logic [W-1:0] src [N],
   output logic [W-1:0] bus
);

   generate
      if (N < 1) begin : g_bad_n
         $error("sbus_busmux: N must be positive");
      end
   endgenerate

   logic [W-1:0] gated [N];

   // AND-OR structure stands in for tri-state drivers
   genvar gi;
   generate
      for (gi = 0; gi < N; gi++) begin : g_lane
         assign gated[gi] = src[gi] & {W{en[gi]}};
      end
   endgenerate

   always_comb begin
      bus = '0;
      for (int i = 0; i < N; i++) bus = bus | gated[i];
   end

   always_comb begin
      if (en == '0)
         AST_IDLE_BUS_ZERO: assert (bus == '0) else $error("idle bus not zero"); // R2
   end

endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath
   import sbus_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 16,
   parameter int OPC_W  = 3,
   parameter int RIDX_W = 4,
   parameter int IMM_W  = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en_rf,
   input  logic              en_mem,
   input  logic              en_alu,
   input  logic              en_pc,
   input  logic              en_imm,
   input  logic              ld_pc,
   input  logic              ld_ir,
   input  logic              ld_mar,
   input  logic              ld_a,
   input  logic              ld_b,
   input  logic              ld_z,
   input  logic              wr_mem,
   input  logic              wr_rf,
   input  logic [1:0]        alu_fn,
   input  logic [1:0]        reg_sel,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic [DATA_W-1:0] rf_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic [RIDX_W-1:0] rf_idx,
   output logic              rf_we,
   output logic [DATA_W-1:0] bus_o,
   output logic [OPC_W-1:0]  opcode,
   output logic              zflag
);

   // instruction field positions
   localparam int OPC_LO = DATA_W - OPC_W;
   localparam int RX_LO  = OPC_LO - RIDX_W;
   localparam int RY_LO  = RX_LO - RIDX_W;
   localparam int RZ_LO  = RY_LO - RIDX_W;

   generate
      if (RZ_LO < 0) begin : g_bad_fields
         $error("sbus_datapath: instruction fields exceed DATA_W");
      end
      if (ADDR_W > DATA_W) begin : g_bad_addr
         $error("sbus_datapath: ADDR_W exceeds DATA_W");
      end
      if (IMM_W > RY_LO || IMM_W < 1) begin : g_bad_imm
         $error("sbus_datapath: IMM_W overlaps register fields");
      end
   endgenerate

   logic [DATA_W-1:0] bus;
   logic [DATA_W-1:0] pc_q, ir_q, mar_q, a_q, b_q;
   logic [DATA_W-1:0] alu_y, imm_ext;
   logic              alu_zero;
   logic [0:0]        z_q;
   logic [DATA_W-1:0] srcs [N_SRC];
   logic [N_SRC-1:0]  src_en;

   sbus_ldreg #(.W(DATA_W)) u_pc  (.clk(clk), .rst(rst), .ld(ld_pc),  .d(bus), .q(pc_q));
   sbus_ldreg #(.W(DATA_W)) u_ir  (.clk(clk), .rst(rst), .ld(ld_ir),  .d(bus), .q(ir_q));
   sbus_ldreg #(.W(DATA_W)) u_mar (.clk(clk), .rst(rst), .ld(ld_mar), .d(bus), .q(mar_q));
   sbus_ldreg #(.W(DATA_W)) u_a   (.clk(clk), .rst(rst), .ld(ld_a),   .d(bus), .q(a_q));
   sbus_ldreg #(.W(DATA_W)) u_b   (.clk(clk), .rst(rst), .ld(ld_b),   .d(bus), .q(b_q));
   sbus_ldreg #(.W(1))      u_z   (.clk(clk), .rst(rst), .ld(ld_z),   .d(alu_zero), .q(z_q));

   sbus_alu #(.W(DATA_W)) u_alu (
      .a(a_q), .b(b_q), .fn(alu_fn), .y(alu_y), .is_zero(alu_zero)
   );

   assign imm_ext = {{(DATA_W-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};

   assign src_en[SRC_RF]  = en_rf;
   assign src_en[SRC_MEM] = en_mem;
   assign src_en[SRC_ALU] = en_alu;
   assign src_en[SRC_PC]  = en_pc;
   assign src_en[SRC_IMM] = en_imm;

   assign srcs[SRC_RF]  = rf_rdata;
   assign srcs[SRC_MEM] = mem_rdata;
   assign srcs[SRC_ALU] = alu_y;
   assign srcs[SRC_PC]  = pc_q;
   assign srcs[SRC_IMM] = imm_ext;

   sbus_busmux #(.W(DATA_W), .N(N_SRC)) u_bus (
      .en(src_en), .src(srcs), .bus(bus)
   );

   always_comb begin
      unique case (reg_sel_e'(reg_sel))
         SEL_X:   rf_idx = ir_q[RX_LO +: RIDX_W];
         SEL_Y:   rf_idx = ir_q[RY_LO +: RIDX_W];
         SEL_Z:   rf_idx = ir_q[RZ_LO +: RIDX_W];
         default: rf_idx = '0;
      endcase
   end

   assign mem_addr = mar_q[ADDR_W-1:0];
   assign mem_we   = wr_mem;
   assign rf_we    = wr_rf;
   assign bus_o    = bus;
   assign opcode   = ir_q[OPC_LO +: OPC_W];
   assign zflag    = z_q[0];

   AST_Z_TRACKS_ZERO_TEST: assert property (@(posedge clk) disable iff (rst)
      ld_z |=> zflag == ($past(alu_y) == '0)) else $error("zero flag capture"); // R6
   AST_MAR_DRIVES_ADDR: assert property (@(posedge clk) disable iff (rst)
      ld_mar |=> mem_addr == $past(bus[ADDR_W-1:0])) else $error("address capture"); // R7
   AST_OPCODE_FROM_IR: assert property (@(posedge clk) disable iff (rst)
      ld_ir |=> opcode == $past(bus[DATA_W-1 -: OPC_W])) else $error("opcode capture"); // R8
   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (zflag == 1'b0 && mem_addr == '0 && opcode == '0)) else $error("reset state"); // R1

endmodule

// File: tb/sbus_datapath_test.sv
module sbus_datapath_test;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic en_rf = 0, en_mem = 0, en_alu = 0, en_pc = 0, en_imm = 0;
   logic ld_pc = 0, ld_ir = 0, ld_mar = 0, ld_a = 0, ld_b = 0, ld_z = 0;
   logic wr_mem = 0, wr_rf = 0;
   logic [1:0]  alu_fn = 2'b00;
   logic [1:0]  reg_sel = 2'b00;
   logic [15:0] mem_rdata = '0;
   logic [15:0] rf_rdata = '0;
   logic [15:0] mem_addr;
   logic        mem_we;
   logic [3:0]  rf_idx;
   logic        rf_we;
   logic [15:0] bus_o;
   logic [2:0]  opcode;
   logic        zflag;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   sbus_datapath uut (
      .clk(clk), .rst(rst),
      .en_rf(en_rf), .en_mem(en_mem), .en_alu(en_alu), .en_pc(en_pc), .en_imm(en_imm),
      .ld_pc(ld_pc), .ld_ir(ld_ir), .ld_mar(ld_mar), .ld_a(ld_a), .ld_b(ld_b), .ld_z(ld_z),
      .wr_mem(wr_mem), .wr_rf(wr_rf), .alu_fn(alu_fn), .reg_sel(reg_sel),
      .mem_rdata(mem_rdata), .rf_rdata(rf_rdata),
      .mem_addr(mem_addr), .mem_we(mem_we), .rf_idx(rf_idx), .rf_we(rf_we),
      .bus_o(bus_o), .opcode(opcode), .zflag(zflag)
   );

   // more than one bus source is a control error
   always @(negedge clk) begin
      if (!rst && $countones({en_rf, en_mem, en_alu, en_pc, en_imm}) > 1) begin
         errors++;
         $display("FAIL R2 multiple bus sources: act %b exp at most one",
                  {en_rf, en_mem, en_alu, en_pc, en_imm});
      end
   end

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act %h exp %h", tag, act, exp);
      end
   endtask

   task automatic idle();
      {en_rf, en_mem, en_alu, en_pc, en_imm} = '0;
      {ld_pc, ld_ir, ld_mar, ld_a, ld_b, ld_z} = '0;
      {wr_mem, wr_rf} = '0;
   endtask

   // advance one edge; inputs change 1 ns after it
   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic load_from_rf(input logic [15:0] v, input string dst);
      idle();
      rf_rdata = v;
      en_rf = 1;
      case (dst)
         "pc":  ld_pc = 1;
         "ir":  ld_ir = 1;
         "mar": ld_mar = 1;
         "a":   ld_a = 1;
         default: ld_b = 1;
      endcase
      step();
      idle();
   endtask

   task automatic t_reset();
      idle();
      en_pc = 1; #1;
      chk("R1 pc after reset", bus_o, 16'h0000);
      chk("R1 mar after reset", mem_addr, 16'h0000);
      chk("R1 opcode after reset", {13'd0, opcode}, 16'h0000);
      chk("R1 zflag after reset", {15'd0, zflag}, 16'h0000);
      idle(); en_alu = 1; alu_fn = 2'b00; #1;
      chk("R1 a+b after reset", bus_o, 16'h0000);
      idle();
   endtask

   task automatic t_bus_sources();
      idle(); rf_rdata = 16'hA5C3; mem_rdata = 16'h3C5A;
      en_rf = 1; #1;
      chk("R2 rf source", bus_o, 16'hA5C3);
      idle(); en_mem = 1; #1;
      chk("R2 mem source", bus_o, 16'h3C5A);
      idle(); #1;
      chk("R2 idle bus", bus_o, 16'h0000);
   endtask

   task automatic t_alu();
      load_from_rf(16'h1234, "a");
      load_from_rf(16'h0FF0, "b");
      en_alu = 1;
      alu_fn = 2'b00; #1; chk("R3 add", bus_o, 16'h2224);
      alu_fn = 2'b01; #1; chk("R3 nand", bus_o, 16'hFDCF);
      alu_fn = 2'b10; #1; chk("R3 sub", bus_o, 16'h0244);
      alu_fn = 2'b11; #1; chk("R3 inc", bus_o, 16'h1235);
      load_from_rf(16'hFFFF, "a");
      en_alu = 1; alu_fn = 2'b11; #1;
      chk("R3 inc wrap", bus_o, 16'h0000);
      idle();
   endtask

   task automatic t_instr_fields();
      load_from_rf(16'h533F, "ir");
      en_imm = 1; #1;
      chk("R4 imm negative", bus_o, 16'hFFFF);
      chk("R8 opcode 533F", {13'd0, opcode}, 16'h0002);
      reg_sel = 2'b00; #1; chk("R9 sel x", {12'd0, rf_idx}, 16'h0009);
      reg_sel = 2'b01; #1; chk("R9 sel y", {12'd0, rf_idx}, 16'h0009);
      reg_sel = 2'b10; #1; chk("R9 sel z", {12'd0, rf_idx}, 16'h000F);
      reg_sel = 2'b11; #1; chk("R9 sel none", {12'd0, rf_idx}, 16'h0000);
      load_from_rf(16'hB201, "ir");
      en_imm = 1; reg_sel = 2'b00; #1;
      chk("R4 imm positive", bus_o, 16'h0001);
      chk("R8 opcode B201", {13'd0, opcode}, 16'h0005);
      chk("R9 sel x B201", {12'd0, rf_idx}, 16'h0009);
      load_from_rf(16'h0F90, "ir");
      en_imm = 1; reg_sel = 2'b01; #1;
      chk("R4 imm sign bit only", bus_o, 16'hFFF0);
      chk("R9 sel y 0F90", {12'd0, rf_idx}, 16'h000C);
      idle();
   endtask

   task automatic t_hold_and_pc_inc();
      load_from_rf(16'h00AA, "pc");
      idle(); rf_rdata = 16'h5555; en_rf = 1; step(); idle();
      en_pc = 1; #1;
      chk("R5 pc holds without load", bus_o, 16'h00AA);
      // pc -> A, then A+1 -> pc
      ld_a = 1; step(); idle();
      en_alu = 1; alu_fn = 2'b11; ld_pc = 1; step(); idle();
      en_pc = 1; #1;
      chk("R5 pc loads increment", bus_o, 16'h00AB);
      idle();
   endtask

   task automatic t_memory();
      load_from_rf(16'h0042, "mar");
      #1;
      chk("R7 address from mar", mem_addr, 16'h0042);
      idle(); rf_rdata = 16'h7777; en_rf = 1; step(); idle(); #1;
      chk("R5 mar holds", mem_addr, 16'h0042);
      en_pc = 1; wr_mem = 1; #1;
      chk("R7 write strobe", {15'd0, mem_we}, 16'h0001);
      chk("R7 write data", bus_o, 16'h00AB);
      idle(); #1;
      chk("R7 strobe low", {15'd0, mem_we}, 16'h0000);
      wr_rf = 1; #1;
      chk("R9 rf write strobe", {15'd0, rf_we}, 16'h0001);
      idle(); #1;
      chk("R9 rf strobe low", {15'd0, rf_we}, 16'h0000);
   endtask

   task automatic t_zero_flag();
      load_from_rf(16'h0005, "a");
      load_from_rf(16'h0005, "b");
      alu_fn = 2'b10; ld_z = 1; step(); idle(); #1;
      chk("R6 equal operands set z", {15'd0, zflag}, 16'h0001);
      load_from_rf(16'h0004, "b");
      alu_fn = 2'b10; ld_z = 1; step(); idle(); #1;
      chk("R6 unequal clears z", {15'd0, zflag}, 16'h0000);
      load_from_rf(16'h0005, "b");
      alu_fn = 2'b10; step(); #1;
      chk("R6 z holds without load", {15'd0, zflag}, 16'h0000);
   endtask

   initial begin
      fork
         begin
            idle();
            repeat (3) @(posedge clk);
            #1 rst = 1'b0;
            t_reset();
            t_bus_sources();
            t_alu();
            t_instr_fields();
            t_hold_and_pc_inc();
            t_memory();
            t_zero_flag();
         end
         begin
            repeat (5000) @(posedge clk);
            errors++;
            $display("FAIL watchdog act timeout exp completion");
         end
      join_any
      disable fork;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule